// File: doc/BRIEF.md
# Accumulator shift and normalize unit

This block holds a 32-bit accumulator together with a small control and status register set. Software programs a shift count, a direction and a carry-enable option, then writes the operand into the accumulator; the write starts the operation. A non-zero count shifts the value by that many bit positions, one position per clock. A count of zero asks for normalization instead. The value moves left until its top bit is set or 31 positions have been applied, and the number of positions used is written back into the count field.

A busy flag covers the whole operation. Software may clear it to abandon the work in progress and return the unit to its initial state. A single shift carry bit can feed the vacated bit and capture the bit pushed out. It survives from one operation to the next and changes otherwise only by software or reset. An overflow flag is held here for an external result checker, which raises it through a one-cycle set input. Reads are registered: the register selected on one clock edge is presented on the read bus until the next.

Top module: `asn_unit`

## Requirements
- R1: With a count field (control bits 4:0) of N in 1..31 and direction 0, writing the accumulator (address 0) shifts it left by N positions, and busy is high for exactly N cycles.
- R2: With a count field of 0, an accumulator write normalizes. The value moves left one position per cycle, with zero fill, until bit 31 is 1 or 31 positions are done. An all-zero value ends as zero after 31 positions.
- R3: When normalization ends, the count field holds the number of positions applied. Busy stays high for that number plus one cycle.
- R4: Control bit 5 selects the direction: 0 moves toward bit 31, 1 moves toward bit 0.
- R5: When control bit 6 (carry-enable) is 1, a shift fills the vacated bit with the shift carry and loads the carry with the bit pushed out. When it is 0, the fill is 0 and the carry is unchanged. Normalization always fills with 0 and leaves the carry unchanged.
- R6: Starting an operation does not clear the shift carry. It changes only through status bit 5 on a write to address 2, through a carry-enabled shift, or through reset, which clears it.
- R7: A write to address 2 with bit 7 at 0 while busy ends the operation. Busy reads 0 on the next cycle, and both the count field and the overflow flag are cleared.
- R8: A pulse on ovf_set sets the overflow flag, status bit 6. Only reset and the abort of R7 clear it. Writing status bit 6 has no effect.
- R9: The status register (address 2) reads busy in bit 7, overflow in bit 6, carry in bit 5, 0 in bit 4 and 1111 in bits 3:0. After reset the status reads 8'h0F, and both the control register and the accumulator read 0.
- R10: While busy, writes to the accumulator (address 0) and to the control register (address 1) are ignored.
- R11: rd_data presents, one clock after the edge that samples rd_addr, the accumulator (0), the control register zero-extended (1), the status register (2), or zero (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 accumulator, 1 control, 2 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| ovf_set | input | 1 | Sets the overflow flag |
| busy | output | 1 | Operation in progress |

## Verification
The hardest case to reach is an abort that lands in the middle of a long operation while the overflow flag is already set. Reaching it shows that the busy flag, the count field and the overflow flag all return to their initial state in the same cycle. The bench raises the flag, starts a 31-position shift, and issues the clearing status write a fixed number of cycles later, so that the write lands while the operation is still running. Writes that arrive during an operation are reached in the same way: they are issued straight after the operand write and must leave the result untouched.

// File: rtl/asn_pkg.sv
package asn_pkg;

  // register addresses on the write and read ports
  typedef enum logic [1:0] {
    SEL_ACC  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status byte layout
  localparam int ST_BUSY  = 7;
  localparam int ST_OVF   = 6;
  localparam int ST_CARRY = 5;
  localparam logic [3:0] ST_ONES = 4'hF;

endpackage

// File: rtl/asn_shifter.sv
// One-position shifter: moves the word one place and reports the bit that leaves.
module asn_shifter #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         to_right,
  input  logic         fill,
  output logic [W-1:0] dout,
  output logic         spill
);

  always_comb begin
    if (to_right) begin
      dout  = {fill, din[W-1:1]};
      spill = din[0];
    end else begin
      dout  = {din[W-2:0], fill};
      spill = din[W-1];
    end
  end

endmodule

// File: rtl/asn_engine.sv
// Accumulator, carry and operation sequencer.
module asn_engine #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  ld_data,
  input  logic [CW-1:0] cnt_in,
  input  logic          dir_right,
  input  logic          carry_en,
  input  logic          abort,
  input  logic          carry_wr,
  input  logic          carry_wd,
  output logic [W-1:0]  acc_q,
  output logic          carry_q,
  output logic          busy_q,
  output logic          wb_valid,
  output logic [CW-1:0] wb_cnt
);

  localparam logic [CW-1:0] MAX_POS = CW'(W - 1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic          norm_q;
  logic [CW-1:0] remain_q;
  logic [CW-1:0] done_q;
  logic [W-1:0]  stepped;
  logic          spill;
  logic          norm_stop;

  asn_shifter #(.W(W)) u_shift (
    .din      (acc_q),
    .to_right (dir_right & ~norm_q),
    .fill     (~norm_q & carry_en & carry_q),
    .dout     (stepped),
    .spill    (spill)
  );

  assign norm_stop = acc_q[W-1] | (done_q == MAX_POS);
  assign wb_valid  = busy_q & norm_q & norm_stop;
  assign wb_cnt    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      carry_q  <= 1'b0;
      busy_q   <= 1'b0;
      norm_q   <= 1'b0;
      remain_q <= '0;
      done_q   <= '0;
    end else begin
      if (abort) begin
        busy_q <= 1'b0;
      end else if (start) begin
        acc_q    <= ld_data;
        busy_q   <= 1'b1;
        norm_q   <= (cnt_in == '0);
        remain_q <= cnt_in;
        done_q   <= '0;
      end else if (busy_q) begin
        if (norm_q) begin
          if (norm_stop) begin
            busy_q <= 1'b0;
          end else begin
            acc_q  <= stepped;
            done_q <= done_q + ONE;
          end
        end else begin
          acc_q    <= stepped;
          remain_q <= remain_q - ONE;
          if (remain_q == ONE) busy_q <= 1'b0;
          if (carry_en) carry_q <= spill;
        end
      end
      // a software write of the carry takes priority over a shift
      if (carry_wr) carry_q <= carry_wd;
    end
  end

endmodule

// File: rtl/asn_csr.sv
// Control fields and overflow flag.
module asn_csr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [CW-1:0] ctl_cnt,
  input  logic          ctl_dir,
  input  logic          ctl_ce,
  input  logic          wb_valid,
  input  logic [CW-1:0] wb_cnt,
  input  logic          init,
  input  logic          ovf_set,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          ce_q,
  output logic          ovf_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      ce_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (init) begin
        cnt_q <= '0;
      end else if (wb_valid) begin
        cnt_q <= wb_cnt;
      end else if (ctl_wr) begin
        cnt_q <= ctl_cnt;
      end
      if (ctl_wr) begin
        dir_q <= ctl_dir;
        ce_q  <= ctl_ce;
      end
      if (init) begin
        ovf_q <= 1'b0;
      end else if (ovf_set) begin
        ovf_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/asn_unit.sv
module asn_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         ovf_set,
  output logic         busy
);
  import asn_pkg::*;

  localparam int CW = $clog2(W);

  logic [W-1:0]  acc_q;
  logic          carry_q;
  logic          busy_q;
  logic          wb_valid;
  logic [CW-1:0] wb_cnt;
  logic [CW-1:0] cnt_q;
  logic          dir_q;
  logic          ce_q;
  logic          ovf_q;
  logic          acc_wr;
  logic          ctl_wr;
  logic          st_wr;
  logic          abort;
  logic [7:0]    status;
  logic [W-1:0]  rd_next;

  assign acc_wr = wr_en & (reg_sel_e'(wr_addr) == SEL_ACC) & ~busy_q;
  assign ctl_wr = wr_en & (reg_sel_e'(wr_addr) == SEL_CTL) & ~busy_q;
  assign st_wr  = wr_en & (reg_sel_e'(wr_addr) == SEL_STAT);
  assign abort  = st_wr & ~wr_data[ST_BUSY] & busy_q;

  asn_engine #(.W(W), .CW(CW)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (acc_wr),
    .ld_data   (wr_data),
    .cnt_in    (cnt_q),
    .dir_right (dir_q),
    .carry_en  (ce_q),
    .abort     (abort),
    .carry_wr  (st_wr),
    .carry_wd  (wr_data[ST_CARRY]),
    .acc_q     (acc_q),
    .carry_q   (carry_q),
    .busy_q    (busy_q),
    .wb_valid  (wb_valid),
    .wb_cnt    (wb_cnt)
  );

  asn_csr #(.CW(CW)) u_csr (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_cnt  (wr_data[CW-1:0]),
    .ctl_dir  (wr_data[CW]),
    .ctl_ce   (wr_data[CW+1]),
    .wb_valid (wb_valid),
    .wb_cnt   (wb_cnt),
    .init     (abort),
    .ovf_set  (ovf_set),
    .cnt_q    (cnt_q),
    .dir_q    (dir_q),
    .ce_q     (ce_q),
    .ovf_q    (ovf_q)
  );

  assign status = {busy_q, ovf_q, carry_q, 1'b0, ST_ONES};

  always_comb begin
    case (reg_sel_e'(rd_addr))
      SEL_ACC:  rd_next = acc_q;
      SEL_CTL:  rd_next = W'({ce_q, dir_q, cnt_q});
      SEL_STAT: rd_next = W'(status);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign busy = busy_q;

endmodule

// File: rtl/asn_unit_chk.sv
module asn_unit_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          wr_d7,
  input logic [1:0]    rd_addr,
  input logic [3:0]    rd_low,
  input logic          ovf_set,
  input logic          busy_q,
  input logic          ovf_q,
  input logic          carry_q,
  input logic [CW-1:0] cnt_q
);

  logic seen;
  logic abort_req;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  assign abort_req = wr_en & (wr_addr == 2'd2) & ~wr_d7 & busy_q;

  // R1: an accepted operand write makes the unit busy
  a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && !busy_q) |=> busy_q);

  // R7: abort returns to the initial state in one cycle
  a_r7_abort_init: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> (!busy_q && !ovf_q && cnt_q == '0));

  // R8: a set pulse without abort leaves the flag raised
  a_r8_ovf_raise: assert property (@(posedge clk) disable iff (rst)
    (ovf_set && !abort_req) |=> ovf_q);

  // R6: an idle unit keeps its carry unless status is written
  a_r6_carry_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !(wr_en && wr_addr == 2'd2)) |=> $stable(carry_q));

  // R9: the fixed low nibble of the status register reads as ones
  a_r9_fixed_ones: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(rd_addr) == 2'd2) |-> rd_low == 4'hF);

endmodule

bind asn_unit asn_unit_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_d7   (wr_data[7]),
  .rd_addr (rd_addr),
  .rd_low  (rd_data[3:0]),
  .ovf_set (ovf_set),
  .busy_q  (busy_q),
  .ovf_q   (ovf_q),
  .carry_q (carry_q),
  .cnt_q   (cnt_q)
);

// File: tb/asn_unit_bench.sv
`timescale 1ns/1ps
module asn_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        ovf_set = 1'b0;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  asn_unit u_asn_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ovf_set(ovf_set), .busy(busy)
  );

  // {carry in, carry-enable, direction, count[4:0], operand[31:0]}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 5'd4,  32'h1234_5678},
    {1'b0, 1'b0, 1'b1, 5'd4,  32'h1234_5678},
    {1'b1, 1'b1, 1'b0, 5'd1,  32'h8000_0001},
    {1'b1, 1'b1, 1'b1, 5'd1,  32'h0000_0003},
    {1'b0, 1'b1, 1'b0, 5'd31, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 1'b1, 5'd31, 32'hA5A5_A5A5},
    {1'b1, 1'b1, 1'b1, 5'd16, 32'h0000_FFFF},
    {1'b0, 1'b0, 1'b0, 5'd0,  32'h0001_0000},
    {1'b0, 1'b0, 1'b0, 5'd0,  32'h8000_0000},
    {1'b0, 1'b0, 1'b0, 5'd0,  32'h0000_0001},
    {1'b0, 1'b0, 1'b0, 5'd0,  32'h0000_0000},
    {1'b1, 1'b1, 1'b0, 5'd0,  32'h0000_0F00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 200) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [32:0] mdl_shift(logic [31:0] v, int n, bit dir, bit ce, bit cin);
    logic c = cin;
    logic o;
    for (int i = 0; i < n; i++) begin
      if (!dir) begin o = v[31]; v = {v[30:0], ce ? c : 1'b0}; end
      else      begin o = v[0];  v = {ce ? c : 1'b0, v[31:1]}; end
      if (ce) c = o;
    end
    return {c, v};
  endfunction

  function automatic int mdl_lz(logic [31:0] v);
    int n = 0;
    while (n < 31 && v[31 - n] == 1'b0) n++;
    return n;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state of all registers
    rd(2'd2, r); chk("R9 reset status", r, 32'h0F);
    rd(2'd1, r); chk("R9 reset control", r, 32'h0);
    rd(2'd0, r); chk("R9 reset accumulator", r, 32'h0);
    chk("R9 reset busy", {31'b0, busy}, 32'h0);
    rd(2'd3, r); chk("R11 unused address", r, 32'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic cin, ce, dir;
      logic [4:0] cnt;
      logic [31:0] op, ea, ectl;
      logic ec;
      logic [32:0] m;
      int ecyc, lz;
      string tag;
      {cin, ce, dir, cnt, op} = VEC[i];
      if (cnt != 0) begin
        m = mdl_shift(op, int'(cnt), dir, ce, cin);
        ea = m[31:0]; ec = m[32]; ecyc = int'(cnt);
        ectl = {25'b0, ce, dir, cnt};
        tag = dir ? "R4" : "R1";
      end else begin
        lz = mdl_lz(op);
        ea = op << lz; ec = cin; ecyc = lz + 1;
        ectl = {25'b0, ce, dir, 5'(lz)};
        tag = "R2";
      end
      wr(2'd2, {24'b0, 1'b1, 1'b0, cin, 5'b0});
      wr(2'd1, {25'b0, ce, dir, cnt});
      wr(2'd0, op);
      wait_idle(cyc);
      chk({tag, " busy cycles R3"}, 32'(cyc), 32'(ecyc));
      rd(2'd0, r); chk({tag, " result"}, r, ea);
      rd(2'd1, r); chk("R3 count field", r, ectl);
      rd(2'd2, r); chk("R5 carry in status", r, {24'b0, 1'b0, 1'b0, ec, 1'b0, 4'hF});
    end

    // R6: carry survives a start with carry-enable off
    wr(2'd2, 32'hA0);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h1);
    wait_idle(cyc);
    rd(2'd2, r); chk("R6 carry kept", r, 32'h2F);
    rd(2'd0, r); chk("R6 result", r, 32'h4);

    // R10: writes during an operation are ignored
    wr(2'd1, 32'd8);
    wr(2'd0, 32'h0000_00FF);
    wr(2'd1, {25'b0, 1'b0, 1'b1, 5'd3});
    wr(2'd0, 32'hDEAD_BEEF);
    wait_idle(cyc);
    rd(2'd0, r); chk("R10 accumulator unchanged", r, 32'h0000_FF00);
    rd(2'd1, r); chk("R10 control unchanged", r, 32'd8);

    // R8 and R7: raise overflow, then abort a long shift
    @(negedge clk); ovf_set = 1'b1;
    @(negedge clk); ovf_set = 1'b0;
    rd(2'd2, r); chk("R8 overflow set", r, 32'h6F);
    wr(2'd1, 32'd31);
    wr(2'd0, 32'h1);
    chk("R7 busy before abort", {31'b0, busy}, 32'h1);
    wr(2'd2, 32'h20);
    chk("R7 busy after abort", {31'b0, busy}, 32'h0);
    rd(2'd1, r); chk("R7 count cleared", r, 32'h0);
    rd(2'd2, r); chk("R7 overflow cleared", r, 32'h2F);

    // R8: software cannot set the overflow bit
    wr(2'd2, 32'hC0);
    rd(2'd2, r); chk("R8 status write no effect", r, 32'h0F);

    // R6 and R9: reset clears the carry
    wr(2'd2, 32'hA0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(2'd2, r); chk("R6 reset clears carry", r, 32'h0F);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule